// File: doc/BRIEF.md
# Next Program Counter Selector with Branch Condition

This block works out the address of the next instruction in a single-cycle processor core. It is purely combinational. Each cycle it takes the current program counter, the fetched instruction word, the values of the two source registers, and two decoded indications from the main control: "this is a direct jump" and "this is a conditional branch". From these it returns the next program counter and a branch-condition flag.

The condition flag comes from the branch opcode in the instruction's top six bits. Four comparisons are supported: two registers equal, two registers different, first register at or below zero (signed), and first register above zero (signed). Three candidate addresses are formed in parallel. The first is the sequential address, the PC plus four. The second is the branch target, the sequential address plus the sign-extended 16-bit offset times four. The third is the direct jump target, built from the upper four PC bits, the 26-bit index field and two zero bits.

The choice is made in two levels. The jump select, when set, overrides everything. Otherwise the branch select, which is the branch indication ANDed with the condition flag, picks the branch target over the sequential address. There is no delay slot, so a taken branch redirects the very next fetch. Register-indirect jumps and link writes are handled elsewhere.

Top module: `nextpc_unit`

## Requirements
- R1: When `jump_i` is high, `next_pc_o` equals {`pc_i`[31:28], `instr_i`[25:0], 2'b00}, whatever the values of `branch_i` and `bcond_o`.
- R2: When `jump_i` is low, `branch_i` is high and `bcond_o` is high, `next_pc_o` equals `pc_i` + 4 + (sign-extended `instr_i`[15:0] × 4).
- R3: With opcode `instr_i`[31:26] = 6'b000100 (equal test), `bcond_o` is high exactly when `rs_val_i` equals `rt_val_i`.
- R4: With opcode 6'b000101 (not-equal test), `bcond_o` is high exactly when `rs_val_i` differs from `rt_val_i`.
- R5: With opcode 6'b000110 (at-or-below-zero test), `bcond_o` is high exactly when `rs_val_i` read as signed is ≤ 0. `rt_val_i` has no effect.
- R6: With opcode 6'b000111 (above-zero test), `bcond_o` is high exactly when `rs_val_i` read as signed is > 0. `rt_val_i` has no effect.
- R7: For every other opcode, `bcond_o` is low.
- R8: When `jump_i` is low and the branch is not taken (`branch_i` low or `bcond_o` low), `next_pc_o` equals `pc_i` + 4. No delay slot is inserted.
- R9: The sequential and branch-target additions wrap modulo 2^32.
- R10: When `branch_i` is low, a high `bcond_o` does not change `next_pc_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| jump_i | input | 1 | Decoded direct jump (plain or linking) |
| branch_i | input | 1 | Decoded conditional branch |
| next_pc_o | output | 32 | Address of the next instruction |
| bcond_o | output | 1 | Branch condition satisfied |

## Verification
Each comparison opcode is exercised with operand pairs that sit on both sides of its decision line: equal versus unequal words, and zero, one, all-ones and the most negative value for the sign tests. This separates a signed comparison from an unsigned one and shows whether the second operand is wrongly used. Jumps are applied while a taken branch is also signalled, which confirms that the jump select has priority. A condition that is true but not flagged as a branch shows that the branch indication gates the select. Program counters near the top and bottom of the address space, with backward and forward offsets, check the wraparound, the sign extension and that the upper PC nibble is kept in the jump target.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_BR_EQ  = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_BR_NE  = 6'b000101;
    localparam logic [OPC_W-1:0] OPC_BR_LEZ = 6'b000110;
    localparam logic [OPC_W-1:0] OPC_BR_GTZ = 6'b000111;

    typedef enum logic [2:0] {
        CMP_NONE,
        CMP_EQ,
        CMP_NE,
        CMP_LEZ,
        CMP_GTZ
    } cmp_kind_e;

    function automatic cmp_kind_e decode_cmp(input logic [OPC_W-1:0] opc);
        cmp_kind_e k;
        case (opc)
            OPC_BR_EQ:  k = CMP_EQ;
            OPC_BR_NE:  k = CMP_NE;
            OPC_BR_LEZ: k = CMP_LEZ;
            OPC_BR_GTZ: k = CMP_GTZ;
            default:    k = CMP_NONE;
        endcase
        return k;
    endfunction

    typedef struct packed {
        logic jmp_sel;
        logic br_sel;
    } pc_sel_t;

endpackage

// File: rtl/nextpc_cond_eval.sv
module nextpc_cond_eval
    import nextpc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cmp_kind_e        kind_i,
    input  logic [XLEN-1:0]  rs_i,
    input  logic [XLEN-1:0]  rt_i,
    output logic             cond_o
);
    logic same;
    logic rs_zero;
    logic rs_neg;

    assign same    = (rs_i == rt_i);
    assign rs_zero = (rs_i == '0);
    assign rs_neg  = rs_i[XLEN-1];

    always_comb begin
        case (kind_i)
            CMP_EQ:  cond_o = same;
            CMP_NE:  cond_o = !same;
            CMP_LEZ: cond_o = rs_neg || rs_zero;
            CMP_GTZ: cond_o = !rs_neg && !rs_zero;
            default: cond_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/nextpc_target_gen.sv
module nextpc_target_gen #(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 16,
    parameter int JIDX_W  = 26,
    parameter int ALIGN_W = 2
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [JIDX_W-1:0] jidx_i,
    output logic [XLEN-1:0]   seq_o,
    output logic [XLEN-1:0]   br_o,
    output logic [XLEN-1:0]   jmp_o
);
    localparam int EXT_W = XLEN - IMM_W - ALIGN_W;
    localparam int NIB_W = XLEN - JIDX_W - ALIGN_W;
    localparam logic [XLEN-1:0] STEP = XLEN'(1) << ALIGN_W;

    logic [XLEN-1:0] offset;

    assign offset = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, {ALIGN_W{1'b0}}};
    assign seq_o  = pc_i + STEP;
    assign br_o   = seq_o + offset;
    assign jmp_o  = {pc_i[XLEN-1 -: NIB_W], jidx_i, {ALIGN_W{1'b0}}};
endmodule

// File: rtl/nextpc_select.sv
module nextpc_select
    import nextpc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  pc_sel_t          sel_i,
    input  logic [XLEN-1:0]  seq_i,
    input  logic [XLEN-1:0]  br_i,
    input  logic [XLEN-1:0]  jmp_i,
    output logic [XLEN-1:0]  next_o
);
    logic [XLEN-1:0] inner;

    assign inner  = sel_i.br_sel  ? br_i  : seq_i;
    assign next_o = sel_i.jmp_sel ? jmp_i : inner;
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
    import nextpc_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 16,
    parameter int JIDX_W  = 26,
    parameter int ALIGN_W = 2
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] instr_i,
    input  logic [XLEN-1:0] rs_val_i,
    input  logic [XLEN-1:0] rt_val_i,
    input  logic            jump_i,
    input  logic            branch_i,
    output logic [XLEN-1:0] next_pc_o,
    output logic            bcond_o
);
    logic [OPC_W-1:0] opc;
    cmp_kind_e        kind;
    pc_sel_t          sel;
    logic [XLEN-1:0]  seq_pc;
    logic [XLEN-1:0]  br_pc;
    logic [XLEN-1:0]  jmp_pc;

    assign opc  = instr_i[XLEN-1 -: OPC_W];
    assign kind = decode_cmp(opc);

    nextpc_cond_eval #(.XLEN(XLEN)) i_cond (
        .kind_i (kind),
        .rs_i   (rs_val_i),
        .rt_i   (rt_val_i),
        .cond_o (bcond_o)
    );

    nextpc_target_gen #(
        .XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W), .ALIGN_W(ALIGN_W)
    ) i_tgt (
        .pc_i   (pc_i),
        .imm_i  (instr_i[IMM_W-1:0]),
        .jidx_i (instr_i[JIDX_W-1:0]),
        .seq_o  (seq_pc),
        .br_o   (br_pc),
        .jmp_o  (jmp_pc)
    );

    assign sel.jmp_sel = jump_i;
    assign sel.br_sel  = branch_i && bcond_o;

    nextpc_select #(.XLEN(XLEN)) i_sel (
        .sel_i  (sel),
        .seq_i  (seq_pc),
        .br_i   (br_pc),
        .jmp_i  (jmp_pc),
        .next_o (next_pc_o)
    );
endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk
    import nextpc_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 16,
    parameter int JIDX_W  = 26,
    parameter int ALIGN_W = 2
) (
    input logic [XLEN-1:0] pc_i,
    input logic [XLEN-1:0] instr_i,
    input logic [XLEN-1:0] rs_val_i,
    input logic [XLEN-1:0] rt_val_i,
    input logic            jump_i,
    input logic            branch_i,
    input logic [XLEN-1:0] next_pc_o,
    input logic            bcond_o
);
    localparam int NIB_W = XLEN - JIDX_W - ALIGN_W;

    logic [OPC_W-1:0] op;
    logic             known;
    logic [XLEN-1:0]  fall;

    assign op    = instr_i[XLEN-1 -: OPC_W];
    assign known = !$isunknown({pc_i, instr_i, rs_val_i, rt_val_i, jump_i, branch_i});
    assign fall  = pc_i + (XLEN'(1) << ALIGN_W);

    always_comb begin
        if (known) begin
            // R1
            jump_target_chk: assert (!jump_i ||
                (next_pc_o[XLEN-1 -: NIB_W] == pc_i[XLEN-1 -: NIB_W] &&
                 next_pc_o[ALIGN_W-1:0] == '0 &&
                 next_pc_o[XLEN-NIB_W-1:ALIGN_W] == instr_i[JIDX_W-1:0]));
            // R8
            fall_through_chk: assert (jump_i || (branch_i && bcond_o) || next_pc_o == fall);
            // R2
            taken_forward_chk: assert (jump_i || !(branch_i && bcond_o) ||
                (next_pc_o - fall) == XLEN'({{(XLEN-IMM_W){instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]} << ALIGN_W));
            // R3
            eq_cond_chk: assert (op != OPC_BR_EQ || bcond_o == (rs_val_i == rt_val_i));
            // R4
            ne_cond_chk: assert (op != OPC_BR_NE || bcond_o != (rs_val_i == rt_val_i));
            // R5
            lez_cond_chk: assert (op != OPC_BR_LEZ || bcond_o == ($signed(rs_val_i) <= 0));
            // R6
            gtz_cond_chk: assert (op != OPC_BR_GTZ || bcond_o == ($signed(rs_val_i) > 0));
            // R7
            other_op_chk: assert (op == OPC_BR_EQ || op == OPC_BR_NE ||
                                  op == OPC_BR_LEZ || op == OPC_BR_GTZ || !bcond_o);
        end
    end
endmodule

bind nextpc_unit nextpc_unit_chk #(
    .XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W), .ALIGN_W(ALIGN_W)
) i_nextpc_unit_chk (
    .pc_i      (pc_i),
    .instr_i   (instr_i),
    .rs_val_i  (rs_val_i),
    .rt_val_i  (rt_val_i),
    .jump_i    (jump_i),
    .branch_i  (branch_i),
    .next_pc_o (next_pc_o),
    .bcond_o   (bcond_o)
);

// File: tb/test_nextpc_unit.sv
module test_nextpc_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct {
        logic [31:0] pc;
        logic        bc;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_i = '0, instr_i = '0, rs_val_i = '0, rt_val_i = '0;
    logic        jump_i = 1'b0, branch_i = 1'b0;
    logic [31:0] next_pc_o;
    logic        bcond_o;

    int   checks = 0;
    int   failures = 0;
    int   cycles = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nextpc_unit i_nextpc_unit (
        .pc_i(pc_i), .instr_i(instr_i), .rs_val_i(rs_val_i), .rt_val_i(rt_val_i),
        .jump_i(jump_i), .branch_i(branch_i),
        .next_pc_o(next_pc_o), .bcond_o(bcond_o)
    );

    function automatic logic model_cond(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        case (ins[31:26])
            6'b000100: return a == b;
            6'b000101: return a != b;
            6'b000110: return $signed(a) <= 0;
            6'b000111: return $signed(a) > 0;
            default:   return 1'b0;
        endcase
    endfunction

    task automatic drive(input logic [31:0] pc, input logic [31:0] ins,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic j, input logic br, input string tag);
        exp_t e;
        logic c;
        @(negedge clk);
        pc_i = pc; instr_i = ins; rs_val_i = a; rt_val_i = b;
        jump_i = j; branch_i = br;
        c = model_cond(ins, a, b);
        e.bc  = c;
        e.tag = tag;
        if (j)            e.pc = {pc[31:28], ins[25:0], 2'b00};
        else if (br && c) e.pc = pc + 32'd4 + {{14{ins[15]}}, ins[15:0], 2'b00};
        else              e.pc = pc + 32'd4;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (next_pc_o !== e.pc || bcond_o !== e.bc) begin
                failures++;
                $display("FAIL %s: next_pc=%h bcond=%b expected next_pc=%h bcond=%b",
                         e.tag, next_pc_o, bcond_o, e.pc, e.bc);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // idle inputs: sequential address (R8)
        drive(32'h0, 32'h0, 32'h0, 32'h0, 0, 0, "R8 idle");
        // R1 jump, plus priority over a taken branch
        drive(32'hA000_1000, {6'b000010, 26'h3FF_FFFF}, 0, 0, 1, 0, "R1 jump");
        drive(32'h5000_0000, {6'b000100, 26'h012_3456}, 7, 7, 1, 1, "R1 jump over taken branch");
        // R3 equal test, taken forward / backward, not taken
        drive(32'h0000_1000, {6'b000100, 10'h0, 16'h0010}, 32'h55, 32'h55, 0, 1, "R3 R2 eq taken fwd");
        drive(32'h0000_1000, {6'b000100, 10'h0, 16'hFFFE}, 32'h55, 32'h55, 0, 1, "R3 R2 eq taken back");
        drive(32'h0000_1000, {6'b000100, 10'h0, 16'h0010}, 32'h55, 32'h54, 0, 1, "R3 R8 eq not taken");
        // R4
        drive(32'h0000_2000, {6'b000101, 10'h0, 16'h0004}, 32'h1, 32'h2, 0, 1, "R4 ne taken");
        drive(32'h0000_2000, {6'b000101, 10'h0, 16'h0004}, 32'h9, 32'h9, 0, 1, "R4 ne not taken");
        // R5 with rt deliberately varied
        drive(32'h0000_3000, {6'b000110, 10'h0, 16'h0008}, 32'h0, 32'hFFFF_FFFF, 0, 1, "R5 lez zero");
        drive(32'h0000_3000, {6'b000110, 10'h0, 16'h0008}, 32'h8000_0000, 32'h0, 0, 1, "R5 lez most negative");
        drive(32'h0000_3000, {6'b000110, 10'h0, 16'h0008}, 32'h1, 32'h1, 0, 1, "R5 lez positive");
        // R6
        drive(32'h0000_4000, {6'b000111, 10'h0, 16'h0002}, 32'h1, 32'h8000_0000, 0, 1, "R6 gtz one");
        drive(32'h0000_4000, {6'b000111, 10'h0, 16'h0002}, 32'h0, 32'h5, 0, 1, "R6 gtz zero");
        drive(32'h0000_4000, {6'b000111, 10'h0, 16'h0002}, 32'hFFFF_FFFF, 32'h5, 0, 1, "R6 gtz minus one");
        drive(32'h0000_4000, {6'b000111, 10'h0, 16'h0002}, 32'h7FFF_FFFF, 32'h0, 0, 1, "R6 gtz max");
        // R7
        drive(32'h0000_5000, {6'b001000, 10'h0, 16'h0040}, 32'h3, 32'h3, 0, 1, "R7 other opcode");
        drive(32'h0000_5000, {6'b000000, 10'h0, 16'h0040}, 32'h0, 32'h0, 0, 1, "R7 zero opcode");
        // R10 condition true but no branch indication
        drive(32'h0000_6000, {6'b000100, 10'h0, 16'h0100}, 32'h4, 32'h4, 0, 0, "R10 cond without branch");
        // R9 wraparound
        drive(32'hFFFF_FFFC, 32'h0, 0, 0, 0, 0, "R9 seq wrap");
        drive(32'h0000_0000, {6'b000100, 10'h0, 16'hFFFE}, 0, 0, 0, 1, "R9 branch wrap below zero");
        drive(32'hFFFF_FFF0, {6'b000100, 10'h0, 16'h0010}, 0, 0, 0, 1, "R9 branch wrap above top");
        @(negedge clk);
        while (q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule